// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive FIFO

This block recovers asynchronous serial characters from a single line input. Its clock runs at sixteen times the bit rate, so every clock edge is one oversampling tick. A falling edge on the idle-high line starts a character. The start bit is confirmed at its centre, and every later bit is sampled at its own centre. The block then removes the framing bits, checks parity and the stop bit, and writes the character into a 16-entry FIFO together with its own parity, framing and break flags.

An external interrupt unit reads four indications from the block: a data-available flag, a trigger-level flag with four selectable levels, a character-timeout flag and a sticky overrun flag. A single-cycle pop strobe removes the head entry. The character in use is the one at the head, and its flags are shown beside it. Each completed character waits three clock cycles in a small delay line before it enters the FIFO. This delay is what sets the fixed latency from the stop-bit sample to the FIFO-driven flags.

Top module: `uart_rx_fifo`

## Requirements
- R1: A character is a low start bit, then `cfg_len`+5 data bits sent LSB first (`cfg_len` 00=5 bits … 11=8 bits), then an optional parity bit, then a stop bit. Each bit is 16 clocks long. Data bits above the character length read as zero.
- R2: When `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0 the expected parity bit makes the count of ones across data and parity even; with `cfg_par_odd`=1 it makes the count odd. A mismatch sets the entry's `rd_perr`. When `cfg_par_en`=0, `rd_perr` is always 0.
- R3: A start bit is re-sampled at its 8th tick. If the line is high at that point, the start is discarded and no entry is produced.
- R4: A stop bit sampled low sets the entry's `rd_ferr`. The receiver then waits for the line to go high before it looks for a new start.
- R5: A break (data, parity and stop positions all low) produces exactly one entry, with data 0 and both `rd_brk` and `rd_ferr` set, however long the line stays low.
- R6: The FIFO holds 16 entries and returns them in arrival order. `rd_pop` removes the head. A pop while the FIFO is empty changes nothing.
- R7: A character that completes while 16 entries are held is discarded and the stored entries stay intact. `overrun` is then set, and the next pop clears it.
- R8: `data_avail`, `trig_hit` and `overrun` change 3 clock cycles after the stop-bit sample. If the line falls just before clock edge E0, the stop sample is at edge E0+26+16·n, where n is the number of data plus parity bits, so the flags update at edge E0+29+16·n.
- R9: `trig_hit` is 1 while the number of held entries is at least the level chosen by `cfg_trig` (00=1, 01=4, 10=8, 11=14).
- R10: `char_timeout` rises when the FIFO is non-empty and no entry has been written or popped for 64·b+8 clock cycles, where b = 2+data bits+parity bits. That is four character times plus an 8-cycle delay. A write or a pop clears it.
- R11: After reset, `data_avail`, `trig_hit`, `char_timeout` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length select (5 + value) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_trig | input | 2 | Trigger level select |
| rd_pop | input | 1 | Pop strobe for the head entry |
| rd_data | output | 8 | Head entry data (0 when empty) |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_avail | output | 1 | FIFO holds at least one entry |
| trig_hit | output | 1 | Held count has reached the trigger level |
| char_timeout | output | 1 | Idle timeout with data waiting |
| overrun | output | 1 | A character was lost to a full FIFO |

## Verification
The bench sweeps all four character lengths against no, even and odd parity. It uses data patterns of all zeros, all ones and alternating bits, which separate bit-order, masking and parity-polarity faults. On every character it checks the exact cycle at which `data_avail` rises. Single-fault frames follow: a bad parity bit, a low stop bit, a long break and short false-start pulses. These tell apart the paths for each flag and the re-sampling of the start bit. A run that fills the FIFO checks every trigger level at every fill count and then checks overrun and arrival order. Idle gaps check the exact cycle of the timeout for two frame sizes.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and helpers of the oversampled serial receiver.
// Assumes 8-bit maximum character width and a 2-bit length select (5..8).
package uart_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Number of data bits selected by the length code.
    function automatic int unsigned data_bits(input logic [1:0] len);
        return MIN_BITS + int'(len);
    endfunction

    // FIFO fill level at which the trigger flag asserts.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Brings the asynchronous line into the clock domain through a flop chain.
// Assumes STAGES >= 2; the chain resets to RESET_VAL (line idle level).
module rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
// Module: rx_frame
// Framing state machine: detects a start edge, confirms it at the half-bit
// tick, samples data/parity/stop at bit centres and builds an entry with
// error flags. Completed entries pass a DELAY-cycle line before "push".
// Assumes one clock per oversampling tick, OVS ticks per bit, OVS even.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DELAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_s,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       push,
    output rx_entry_t  push_entry
);
    localparam int TICK_W = $clog2(OVS);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [TICK_W-1:0] HALF_LAST = TICK_W'(OVS/2 - 1);
    localparam logic [TICK_W-1:0] BIT_LAST  = TICK_W'(OVS - 1);

    rx_state_e          state;
    logic [TICK_W-1:0]  tick;
    logic [BIT_W-1:0]   bitn;
    logic [DATA_W-1:0]  shreg;
    logic               par_bit;
    logic               at_centre;
    logic [BIT_W-1:0]   last_bit;
    logic               done;
    rx_entry_t          done_entry;

    logic [DELAY-1:0]   stg_v;
    rx_entry_t          stg_e [DELAY];

    assign at_centre = (tick == BIT_LAST);
    assign last_bit  = BIT_W'(MIN_BITS - 1) + BIT_W'(cfg_len);
    assign done      = (state == ST_STOP) && at_centre;

    // Assemble the finished entry and its flags at the stop-bit sample.
    always_comb begin
        done_entry.data = shreg;
        done_entry.perr = cfg_par_en && (par_bit != ((^shreg) ^ cfg_par_odd));
        done_entry.ferr = !rx_s;
        done_entry.brk  = !rx_s && (shreg == '0) && (!cfg_par_en || !par_bit);
    end

    // Framing state machine with tick and bit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tick    <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tick <= '0;
                    if (!rx_s) state <= ST_START;
                end
                ST_START: begin
                    if (tick == HALF_LAST) begin
                        tick    <= '0;
                        bitn    <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                        state   <= rx_s ? ST_IDLE : ST_DATA;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_DATA: begin
                    tick <= at_centre ? '0 : tick + 1'b1;
                    if (at_centre) begin
                        shreg[bitn] <= rx_s;
                        bitn        <= bitn + 1'b1;
                        if (bitn == last_bit)
                            state <= cfg_par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    tick <= at_centre ? '0 : tick + 1'b1;
                    if (at_centre) begin
                        par_bit <= rx_s;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    tick <= at_centre ? '0 : tick + 1'b1;
                    if (at_centre) state <= rx_s ? ST_IDLE : ST_WAITHI;
                end
                ST_WAITHI: begin
                    tick <= '0;
                    if (rx_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Fixed-latency delay line between the stop sample and the FIFO write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int i = 0; i < DELAY; i++) stg_e[i] <= '0;
        end else begin
            stg_v[0] <= done;
            stg_e[0] <= done_entry;
            for (int i = 1; i < DELAY; i++) begin
                stg_v[i] <= stg_v[i-1];
                stg_e[i] <= stg_e[i-1];
            end
        end
    end

    assign push       = stg_v[DELAY-1];
    assign push_entry = stg_e[DELAY-1];

    // R3: a start not low at the half-bit tick returns to idle.
    assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick == HALF_LAST && rx_s) |=> (state == ST_IDLE));

    // R4: a low line keeps the receiver parked after a bad stop bit.
    assert_wait_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITHI && !rx_s) |=> (state == ST_WAITHI));

    // R5: a break entry carries zero data and a framing error.
    assert_break_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (push_entry.ferr && push_entry.data == '0));
endmodule

// File: rtl/rx_fifo.sv
// Module: rx_fifo
// Entry FIFO with per-entry flags, fill count and sticky overrun.
// Assumes DEPTH is a power of two. A push into a full FIFO with no pop in
// the same cycle is dropped and sets the overrun flag; any pop clears it.
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             empty;
    logic             full;
    logic             do_pop;
    logic             do_push;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    // Entry storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    // Pointers, fill count and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && !do_push) ovr <= 1'b1;
            else if (pop)         ovr <= 1'b0;
        end
    end

    assign head = empty ? '0 : mem[rd_ptr];

    // R6: the count never exceeds the depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R6: a pop on an empty FIFO leaves it empty.
    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push) |=> (count == '0));

    // R7: a write into a full FIFO keeps it full and flags overrun.
    assert_overrun_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CNT_W'(DEPTH) && !pop) |=> (count == CNT_W'(DEPTH) && ovr));
endmodule

// File: rtl/rx_timeout.sv
// Module: rx_timeout
// Idle counter for the character timeout. It clears on any write or pop or
// while the FIFO is empty, and saturates at a limit derived from the frame
// size: TO_CHARS character times plus TO_EXTRA cycles.
// Assumes OVS clocks per bit and a single stop bit in the frame length.
module rx_timeout
    import uart_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int TO_CHARS = 4,
    parameter int TO_EXTRA = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  logic       nonempty,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    output logic       timeout
);
    localparam int MAX_LIMIT = TO_CHARS * OVS * (DATA_W + 3) + TO_EXTRA;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] limit;

    // Limit in cycles for the current frame format.
    always_comb begin
        limit = CNT_W'(TO_CHARS * OVS *
                       (2 + int'(data_bits(cfg_len)) + int'(cfg_par_en)) + TO_EXTRA);
    end

    // Idle cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idle_cnt <= '0;
        else if (push || pop || !nonempty)   idle_cnt <= '0;
        else if (idle_cnt < limit)           idle_cnt <= idle_cnt + 1'b1;
    end

    assign timeout = nonempty && (idle_cnt == limit);

    // R10: the timeout never stands while the FIFO is empty.
    assert_timeout_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> nonempty);

    // R10: a write or pop always drops the timeout in the next cycle.
    assert_timeout_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push || pop) |=> !timeout);
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo (top)
// Oversampled serial receiver feeding a flagged receive FIFO, with
// data-available, trigger, timeout and overrun indications.
// Assumes clk is the 16x oversampling clock and rst_n is synchronous.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DEPTH    = 16,
    parameter int DELAY    = 3,
    parameter int SYNC_STG = 2,
    parameter int TO_CHARS = 4,
    parameter int TO_EXTRA = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_trig,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_avail,
    output logic       trig_hit,
    output logic       char_timeout,
    output logic       overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             rx_s;
    logic             push;
    rx_entry_t        push_entry;
    rx_entry_t        head;
    logic [CNT_W-1:0] count;

    rx_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_s)
    );

    rx_frame #(.OVS(OVS), .DELAY(DELAY)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_s        (rx_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .push        (push),
        .push_entry  (push_entry)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (rd_pop),
        .head       (head),
        .count      (count),
        .ovr        (overrun)
    );

    rx_timeout #(.OVS(OVS), .TO_CHARS(TO_CHARS), .TO_EXTRA(TO_EXTRA)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (rd_pop),
        .nonempty   (data_avail),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .timeout    (char_timeout)
    );

    assign data_avail = (count != '0);
    assign trig_hit   = int'(count) >= int'(trig_level(cfg_trig));
    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign rd_brk     = head.brk;

    // R9: the trigger flag implies at least one held entry.
    assert_trig_avail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> data_avail);

    // R6: an empty FIFO shows no head flags.
    assert_empty_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail |-> !(rd_perr || rd_ferr || rd_brk));
endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk;
    logic       data_avail, trig_hit, char_timeout, overrun;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_rx_fifo i_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_trig(cfg_trig), .rd_pop(rd_pop), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .data_avail(data_avail), .trig_hit(trig_hit),
        .char_timeout(char_timeout), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbits_payload();
        return 5 + int'(cfg_len) + int'(cfg_par_en);
    endfunction

    function automatic logic [7:0] mask_data(input logic [7:0] d);
        return d & 8'(({8'b0, 8'hFF} >> (3 - int'(cfg_len))));
    endfunction

    // Send one frame starting at a negedge; optionally check R8 timing.
    task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v, input bit chk_t);
        logic [11:0] fr;
        int nd = 5 + int'(cfg_len);
        int n = nbits_payload();
        fr = '0;
        for (int i = 0; i < nd; i++) fr[1+i] = d[i];
        if (cfg_par_en) fr[1+nd] = (^mask_data(d)) ^ cfg_par_odd ^ bad_par;
        fr[n+1] = stop_v;
        for (int k = 0; k < 16*(n+2); k++) begin
            rx_line = fr[k/16];
            @(negedge clk);
            if (chk_t && k == 28+16*n) begin
                chk("R8 data_avail before", 32'(data_avail), 0);
                if (cfg_trig == 2'd0) chk("R8 trig_hit before", 32'(trig_hit), 0);
            end
            if (chk_t && k == 29+16*n) begin
                chk("R8 data_avail after", 32'(data_avail), 1);
                if (cfg_trig == 2'd0) chk("R8 trig_hit after", 32'(trig_hit), 1);
            end
        end
        rx_line = 1'b1;
    endtask

    task automatic pop_check(input string req, input logic [7:0] d, input bit pe, input bit fe, input bit bk);
        chk({req, " data"}, 32'(rd_data), 32'(d));
        chk({req, " perr"}, 32'(rd_perr), 32'(pe));
        chk({req, " ferr"}, 32'(rd_ferr), 32'(fe));
        chk({req, " brk"},  32'(rd_brk),  32'(bk));
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 data_avail", 32'(data_avail), 0);
        chk("R11 trig_hit", 32'(trig_hit), 0);
        chk("R11 char_timeout", 32'(char_timeout), 0);
        chk("R11 overrun", 32'(overrun), 0);

        // R1 R2 R8 sweep of lengths, parity modes and patterns
        for (int l = 0; l < 4; l++) begin
            for (int pm = 0; pm < 3; pm++) begin
                cfg_len = 2'(l);
                cfg_par_en = (pm != 0);
                cfg_par_odd = (pm == 2);
                for (int p = 0; p < 4; p++) begin
                    send(pats[p], 0, 1, 1);
                    pop_check("R1 R2 sweep", mask_data(pats[p]), 0, 0, 0);
                    chk("R6 empty after pop", 32'(data_avail), 0);
                end
            end
        end

        // R2 parity errors, both polarities
        cfg_len = 2'd3; cfg_par_en = 1'b1;
        for (int o = 0; o < 2; o++) begin
            cfg_par_odd = o[0];
            send(8'h3C, 1, 1, 1);
            pop_check("R2 bad parity", 8'h3C, 1, 0, 0);
        end

        // R4 framing error without break
        cfg_par_en = 1'b0;
        send(8'h81, 0, 0, 0);
        repeat (40) @(negedge clk);
        pop_check("R4 framing", 8'h81, 0, 1, 0);

        // R5 break held for three frame times: one entry only
        rx_line = 1'b0;
        repeat (16*10*3) @(negedge clk);
        rx_line = 1'b1;
        repeat (60) @(negedge clk);
        chk("R5 break entry present", 32'(data_avail), 1);
        pop_check("R5 break", 8'h00, 0, 1, 1);
        chk("R5 single break entry", 32'(data_avail), 0);

        // R3 false starts of 1..6 low ticks
        for (int w = 1; w <= 6; w++) begin
            rx_line = 1'b0;
            repeat (w) @(negedge clk);
            rx_line = 1'b1;
            repeat (200) @(negedge clk);
            chk("R3 false start dropped", 32'(data_avail), 0);
        end
        send(8'h96, 0, 1, 1);
        pop_check("R3 after false start", 8'h96, 0, 0, 0);

        // R6 pop on empty has no effect
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        chk("R6 pop on empty", 32'(data_avail), 0);
        send(8'h42, 0, 1, 1);
        pop_check("R6 after empty pop", 8'h42, 0, 0, 0);
        chk("R6 single entry", 32'(data_avail), 0);

        // R9 trigger levels at every fill count, then R7 overrun and order
        for (int i = 0; i < 16; i++) begin
            cfg_trig = 2'd0;
            send(8'(i*7+1), 0, 1, 0);
            repeat (4) @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                int lvl;
                cfg_trig = 2'(s);
                lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
                #1;
                chk("R9 trigger level", 32'(trig_hit), 32'((i+1) >= lvl));
            end
        end
        cfg_trig = 2'd0;
        chk("R7 no overrun at full", 32'(overrun), 0);
        send(8'hEE, 0, 1, 0);
        repeat (4) @(negedge clk);
        chk("R7 overrun set", 32'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            pop_check("R7 R6 order kept", 8'(i*7+1), 0, 0, 0);
            if (i == 0) chk("R7 overrun cleared by pop", 32'(overrun), 0);
        end
        chk("R7 drained", 32'(data_avail), 0);

        // R10 timeout exact cycle for two frame sizes
        for (int c = 0; c < 2; c++) begin
            int lim;
            cfg_len = (c == 0) ? 2'd3 : 2'd0;
            cfg_par_en = (c == 1);
            lim = 64 * (2 + nbits_payload()) + 8;
            send(8'h19, 0, 1, 1);
            repeat (lim - 3) @(negedge clk);
            chk("R10 timeout not yet", 32'(char_timeout), 0);
            @(negedge clk);
            chk("R10 timeout raised", 32'(char_timeout), 1);
            pop_check("R10 entry", 8'h19 & ((c == 0) ? 8'hFF : 8'h1F), 0, 0, 0);
            chk("R10 cleared by pop", 32'(char_timeout), 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule